// File: doc/BRIEF.md
# Triggered Event Serial Packet Builder

This block takes one triggered event at a time from an upstream event queue and turns it into a fixed-length serial packet on a single data line, one bit per clock of the 40 MHz readout clock. Each packet carries a short start pattern, the bunch-crossing tag and event count of the event, the identifier of the chip, the hit bit of every one of the 128 channels, and a 16-bit CRC over everything between the start pattern and the CRC. A valid strobe is high for exactly the bits of the packet.

The queue offers an event with a valid signal, and the block accepts it with a ready signal. Ready stays low from the moment an event is accepted until its last CRC bit has left the block. That leaves at least one idle clock between packets. The chip identifier is a static input. It is captured with the event, so a change during a packet only shows up in the next packet.

Top module: `pkt_formatter`

## Requirements
- R1: After reset, and whenever no packet is in progress, `evt_ready` is 1 and `ser_valid` is 0.
- R2: An event is accepted on a rising edge where `evt_valid` and `evt_ready` are both 1. `ser_valid` is 1 in the clock that follows, carrying the first header bit.
- R3: `ser_valid` stays high for exactly 180 consecutive clocks per packet.
- R4: The packet order is: the header 4'b1010, the 12-bit bunch-crossing tag, the 8-bit event count, the 12-bit chip identifier, then the hits from channel 127 down to channel 0. Every field is sent most significant bit first.
- R5: The final 16 bits are a CRC with polynomial 0x1021 and seed 0xFFFF, computed bit-serially over the 160 bits from the bunch-crossing tag through hit channel 0. There is no final inversion, and the CRC is sent most significant bit first.
- R6: `evt_ready` is 0 for the whole packet. A held `evt_valid` is accepted only after the last CRC bit. `ser_valid` is low for at least one clock between two packets.
- R7: `chip_id` is sampled when an event is accepted. A change to it during a packet does not alter that packet.
- R8: `ser_data` is 0 whenever `ser_valid` is 0.
- R9: The event fields are captured at acceptance. A change to `evt_bc`, `evt_ec` or `evt_hits` during a packet does not alter that packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz readout clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_valid | input | 1 | Queue holds an event |
| evt_ready | output | 1 | Block accepts the offered event this edge |
| evt_bc | input | 12 | Bunch-crossing tag of offered event |
| evt_ec | input | 8 | Event count of offered event |
| evt_hits | input | 128 | Hit bits, bit n is channel n |
| chip_id | input | 12 | Static chip identifier |
| ser_data | output | 1 | Serial packet bit |
| ser_valid | output | 1 | High while a packet bit is on ser_data |

## Verification
The last CRC bit and the acceptance of the next event sit next to each other in time, and the bench makes them meet. It holds `evt_valid` high through a whole packet. Midway through that packet it changes the event fields and the chip identifier. The bench then checks four things: the first packet still matches its original fields, `ser_valid` drops for exactly one clock, the new event is accepted in that gap, and the second packet carries the changed fields and identifier with a correct CRC.

// File: rtl/pkt_fmt_pkg.sv
// Shared definitions for the serial packet builder.
// Assumes: packet bits are numbered from 0 at the first header bit.
package pkt_fmt_pkg;

    // Which section of the packet the current bit belongs to.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HDR  = 2'd1,
        PH_BODY = 2'd2,
        PH_CRC  = 2'd3
    } pkt_phase_t;

endpackage

// File: rtl/pkt_seq.sv
// Packet sequencer: counts the bit slots of one packet and names the section.
// Assumes: load only arrives while the sequencer is not busy.
module pkt_seq
    import pkt_fmt_pkg::*;
#(
    parameter int HDR_W   = 4,
    parameter int PAY_W   = 164,
    parameter int PKT_LEN = 180
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    output logic       busy,
    output logic       last,
    output pkt_phase_t phase
);
    localparam int CNT_W = $clog2(PKT_LEN);

    logic [CNT_W-1:0] cnt;

    assign last = busy && (cnt == CNT_W'(PKT_LEN - 1));

    // Bit slot counter and busy flag for the packet in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (load) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            if (last) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    // Section decode from the slot count.
    always_comb begin
        if (!busy)
            phase = PH_IDLE;
        else if (cnt < CNT_W'(HDR_W))
            phase = PH_HDR;
        else if (cnt < CNT_W'(PAY_W))
            phase = PH_BODY;
        else
            phase = PH_CRC;
    end

    // R2: an accepted event starts the packet at slot zero in the next clock.
    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (busy && cnt == '0));

    // R3: slots advance one per clock without a hole until the last one.
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last) |=> (busy && cnt == $past(cnt) + CNT_W'(1)));

    // R6: the clock after the last slot is idle.
    p_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> !busy);

endmodule

// File: rtl/pkt_shifter.sv
// Record shifter: holds header and event record, shifts out MSB first.
// Assumes: shift is high for every slot of a packet, load only while idle.
module pkt_shifter #(
    parameter int W = 164
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic         msb
);
    logic [W-1:0] sh;

    // Capture the record at acceptance, then move one bit per slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sh <= '0;
        else if (load)
            sh <= din;
        else if (shift)
            sh <= {sh[W-2:0], 1'b0};
    end

    assign msb = sh[W-1];

    // R9: the record held is the one presented at acceptance.
    p_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sh == $past(din)));

endmodule

// File: rtl/pkt_crc.sv
// Bit-serial CRC: folds body bits in, then shifts the remainder out MSB first.
// Assumes: clear, upd and shift are mutually exclusive.
module pkt_crc #(
    parameter int         W    = 16,
    parameter logic [W-1:0] POLY = 16'h1021,
    parameter logic [W-1:0] SEED = 16'hFFFF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic upd,
    input  logic bit_in,
    input  logic shift,
    output logic out_bit
);
    logic [W-1:0] crc;
    logic         fb;

    assign fb = crc[W-1] ^ bit_in;

    // Seed, accumulate or drain the remainder.
    always_ff @(posedge clk) begin
        if (!rst_n)
            crc <= SEED;
        else if (clear)
            crc <= SEED;
        else if (upd)
            crc <= {crc[W-2:0], 1'b0} ^ (fb ? POLY : '0);
        else if (shift)
            crc <= {crc[W-2:0], 1'b0};
    end

    assign out_bit = crc[W-1];

    // R5: every packet starts its CRC from the seed.
    p_seed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (crc == SEED));

endmodule

// File: rtl/pkt_formatter.sv
// Serial packet builder top: accepts one event, emits header, tags, hits, CRC.
// Assumes: chip_id is quasi-static; the queue holds evt_* stable while valid.
module pkt_formatter
    import pkt_fmt_pkg::*;
#(
    parameter int         BC_W        = 12,
    parameter int         EC_W        = 8,
    parameter int         ID_W        = 12,
    parameter int         HIT_W       = 128,
    parameter int         HDR_W       = 4,
    parameter logic [3:0] HDR_PATTERN = 4'b1010,
    parameter int         CRC_W       = 16,
    parameter logic [15:0] CRC_POLY   = 16'h1021,
    parameter logic [15:0] CRC_SEED   = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    output logic              evt_ready,
    input  logic [BC_W-1:0]   evt_bc,
    input  logic [EC_W-1:0]   evt_ec,
    input  logic [HIT_W-1:0]  evt_hits,
    input  logic [ID_W-1:0]   chip_id,
    output logic              ser_data,
    output logic              ser_valid
);
    localparam int BODY_W  = BC_W + EC_W + ID_W + HIT_W;
    localparam int PAY_W   = HDR_W + BODY_W;
    localparam int PKT_LEN = PAY_W + CRC_W;

    logic          load;
    logic          busy;
    logic          last;
    pkt_phase_t    phase;
    logic          sh_bit;
    logic          crc_bit;
    logic [PAY_W-1:0] record;

    assign evt_ready = !busy;
    assign load      = evt_valid && evt_ready;
    assign record    = {HDR_PATTERN[HDR_W-1:0], evt_bc, evt_ec, chip_id, evt_hits};

    pkt_seq #(
        .HDR_W   (HDR_W),
        .PAY_W   (PAY_W),
        .PKT_LEN (PKT_LEN)
    ) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .busy  (busy),
        .last  (last),
        .phase (phase)
    );

    pkt_shifter #(
        .W (PAY_W)
    ) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .shift (busy),
        .din   (record),
        .msb   (sh_bit)
    );

    pkt_crc #(
        .W    (CRC_W),
        .POLY (CRC_POLY[CRC_W-1:0]),
        .SEED (CRC_SEED[CRC_W-1:0])
    ) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (load),
        .upd     (phase == PH_BODY),
        .bit_in  (sh_bit),
        .shift   (phase == PH_CRC),
        .out_bit (crc_bit)
    );

    // Output select: record bits, then CRC bits, quiet when idle.
    always_comb begin
        unique case (phase)
            PH_HDR, PH_BODY: ser_data = sh_bit;
            PH_CRC:          ser_data = crc_bit;
            default:         ser_data = 1'b0;
        endcase
    end

    assign ser_valid = busy;

    // R6: a finished packet frees the queue handshake in the next clock.
    p_ready_after_r6: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> evt_ready);

    // R1: the line stays idle unless an event was accepted.
    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_valid && !load) |=> !ser_valid);

endmodule

// File: tb/pkt_formatter_test.sv
module pkt_formatter_test;
    localparam int CLK_PERIOD = 25;
    localparam int LEN = 180;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         evt_valid = 1'b0;
    logic         evt_ready;
    logic [11:0]  evt_bc = '0;
    logic [7:0]   evt_ec = '0;
    logic [127:0] evt_hits = '0;
    logic [11:0]  chip_id = 12'h5A3;
    logic         ser_data;
    logic         ser_valid;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_formatter uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_valid (evt_valid),
        .evt_ready (evt_ready),
        .evt_bc    (evt_bc),
        .evt_ec    (evt_ec),
        .evt_hits  (evt_hits),
        .chip_id   (chip_id),
        .ser_data  (ser_data),
        .ser_valid (ser_valid)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [179:0] act, input logic [179:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference packet built from the requirements (R4, R5).
    function automatic logic [179:0] model(input logic [11:0] bc, input logic [7:0] ec,
                                           input logic [11:0] id, input logic [127:0] h);
        logic [159:0] body;
        logic [15:0]  c;
        logic         fb;
        body = {bc, ec, id, h};
        c = 16'hFFFF;
        for (int i = 159; i >= 0; i--) begin
            fb = c[15] ^ body[i];
            c = {c[14:0], 1'b0};
            if (fb) c = c ^ 16'h1021;
        end
        return {4'b1010, body, c};
    endfunction

    // Offer an event and return at the negedge after the accepting edge.
    task automatic offer(input logic [11:0] bc, input logic [7:0] ec, input logic [127:0] h);
        @(negedge clk);
        evt_bc = bc; evt_ec = ec; evt_hits = h; evt_valid = 1'b1;
        while (!evt_ready) @(negedge clk);
        @(negedge clk);
        chk(ser_valid == 1'b1, "R2", "valid after accept", ser_valid, 1);
    endtask

    // Sample a full packet; optionally change inputs mid-packet.
    task automatic grab(output logic [179:0] got, output int vlen, output int rdy,
                        input bit swap, input logic [11:0] bc2, input logic [7:0] ec2,
                        input logic [127:0] h2, input logic [11:0] id2);
        vlen = 0; rdy = 0; got = '0;
        for (int i = 0; i < LEN; i++) begin
            if (i > 0) @(negedge clk);
            if (ser_valid) vlen++;
            if (evt_ready) rdy++;
            got[179-i] = ser_data;
            if (swap && i == 60) begin
                evt_bc = bc2; evt_ec = ec2; evt_hits = h2; chip_id = id2;
            end
        end
        @(negedge clk);
        chk(ser_valid == 1'b0, "R6", "idle gap after packet", ser_valid, 0);
        chk(evt_ready == 1'b1, "R6", "ready in gap", evt_ready, 1);
    endtask

    task automatic judge(input string tag, input logic [179:0] got, input int vlen, input int rdy,
                         input logic [11:0] bc, input logic [7:0] ec,
                         input logic [11:0] id, input logic [127:0] h);
        logic [179:0] exp;
        exp = model(bc, ec, id, h);
        chk(got[179:16] == exp[179:16], "R4", {tag, " fields"}, got[179:16], exp[179:16]);
        chk(got[15:0] == exp[15:0], "R5", {tag, " crc"}, got[15:0], exp[15:0]);
        chk(vlen == LEN, "R3", {tag, " valid length"}, vlen, LEN);
        chk(rdy == 0, "R6", {tag, " ready low in packet"}, rdy, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(evt_ready == 1'b1, "R1", "ready after reset", evt_ready, 1);
        chk(ser_valid == 1'b0, "R1", "valid after reset", ser_valid, 0);
        chk(ser_data == 1'b0, "R8", "data after reset", ser_data, 0);
    endtask

    task automatic t_single(input string tag, input logic [11:0] bc, input logic [7:0] ec,
                            input logic [127:0] h);
        logic [179:0] got; int vlen; int rdy;
        offer(bc, ec, h);
        evt_valid = 1'b0;
        grab(got, vlen, rdy, 1'b0, '0, '0, '0, chip_id);
        judge(tag, got, vlen, rdy, bc, ec, chip_id, h);
    endtask

    task automatic t_back_to_back();
        logic [179:0] got; int vlen; int rdy;
        logic [11:0] id_a;
        id_a = chip_id;
        offer(12'hABC, 8'h3C, {32{4'h9}});
        grab(got, vlen, rdy, 1'b1, 12'h123, 8'hE7, {64{2'b10}}, 12'h0F1);
        judge("first, inputs changed mid-packet R7 R9", got, vlen, rdy,
              12'hABC, 8'h3C, id_a, {32{4'h9}});
        @(negedge clk);
        chk(ser_valid == 1'b1, "R6", "held valid accepted after one idle clock", ser_valid, 1);
        evt_valid = 1'b0;
        grab(got, vlen, rdy, 1'b0, '0, '0, '0, chip_id);
        judge("second, new id R7", got, vlen, rdy, 12'h123, 8'hE7, 12'h0F1, {64{2'b10}});
    endtask

    task automatic t_idle_quiet();
        int bad;
        bad = 0;
        evt_valid = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chip_id = chip_id ^ 12'hFFF;
            evt_hits = ~evt_hits;
            if (ser_valid || ser_data || !evt_ready) bad++;
        end
        chk(bad == 0, "R8", "line quiet while idle (R1)", bad, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_single("basic", 12'h5C1, 8'h2D, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210);
        t_single("all zero hits", 12'h000, 8'h00, '0);
        t_single("all one hits", 12'hFFF, 8'hFF, '1);
        t_single("channel 0 only", 12'h800, 8'h01, 128'h1);
        t_back_to_back();
        t_idle_quiet();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule